// File: doc/BRIEF.md
# One-Way ROM Access Handover Mux

This block decides who may read the ROM: the boot-time integrity checker or the system bus. After reset the checker holds the ROM. A 4-bit encoded ownership select later hands it to the bus, and ownership never goes back. The ROM array sits outside the block. It returns read data one cycle after a request. The mux routes the request and address to the ROM and steers the returned data to whichever side issued the read. That side also gets a one-cycle response valid.

The block keeps a registered copy of the select and watches both the live and registered values. Two kinds of select fault raise a fatal alert that stays high until reset:

- an encoding that is neither legal value;
- any move from bus ownership back to checker ownership.

Once such a fault has been seen, no bus response valid is produced, so the bus never consumes data that might be wrong. The ROM address leaves the block on two copies, each from its own multiplexer. A single fault therefore cannot bend the address seen downstream.

Top module: `rom_access_mux`

## Requirements
- R1: After reset, and while the select carries the checker code 4'b1001, checker requests drive the ROM request and address, and the bus-side ready stays low even when the bus requests.
- R2: With the select at the bus code 4'b0110, bus-side ready is high, bus requests drive the ROM request and address, and checker requests no longer reach the ROM.
- R3: A select value other than 4'b1001 or 4'b0110 sets the fatal alert on the next clock edge.
- R4: A return of the select from 4'b0110 to 4'b1001 sets the fatal alert on the next clock edge. The checker gets no ROM access in that cycle or later.
- R5: The fatal alert is low out of reset. Once set, it stays high until reset, whatever the select does afterwards.
- R6: A checker request accepted in one cycle produces a checker response valid in the next cycle, carrying the ROM read data for that address.
- R7: A bus request accepted (request with ready) in one cycle produces a bus response valid in the next cycle, carrying the ROM read data for that address.
- R8: The bus response valid is held low while the alert is high and in the cycle in which a select fault is first present.
- R9: Both ROM address outputs equal the address of the side currently granted.
- R10: While the select holds an illegal value, neither side is granted: ROM request and bus-side ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| own_sel_i | input | 4 | Encoded owner select: 4'b1001 checker, 4'b0110 bus |
| chk_req_i | input | 1 | Checker read request |
| chk_addr_i | input | ADDR_W | Checker word address |
| chk_rvalid_o | output | 1 | Checker response valid |
| chk_rdata_o | output | DATA_W | Checker response data |
| bus_req_i | input | 1 | Bus read request |
| bus_addr_i | input | ADDR_W | Bus word address |
| bus_ready_o | output | 1 | Bus request accepted this cycle |
| bus_rvalid_o | output | 1 | Bus response valid |
| bus_rdata_o | output | DATA_W | Bus response data |
| rom_req_o | output | 1 | ROM read strobe |
| rom_addr_o | output | ADDR_W | ROM address, primary path |
| rom_addr_dup_o | output | ADDR_W | ROM address, redundant path |
| rom_rdata_i | input | DATA_W | ROM read data, one cycle after the strobe |
| alert_o | output | 1 | Sticky fatal alert |

## Verification
Fault detection and response delivery can land in the same cycle. This happens when a bus read is accepted and the select turns illegal in the very next cycle, while that read's response is due. The bench builds exactly that sequence. It checks that bus response valid is low in the fault cycle and that nothing is queued for the monitor to receive. The monitor also fails on any bus response that arrives with an empty expectation queue, including responses after the select goes back to the bus code while the alert is still set.

// File: rtl/rom_mux_pkg.sv
package rom_mux_pkg;

   localparam int unsigned SelW = 4;
   typedef logic [SelW-1:0] sel_t;

   // Complementary codes: no single-bit flip moves between them.
   localparam sel_t SelBus = 4'b0110;
   localparam sel_t SelChk = 4'b1001;

   // Number of independent address multiplexers feeding the ROM.
   localparam int unsigned NumAddrPaths = 2;

   typedef enum logic [1:0] {
      OwnNone = 2'b00,
      OwnChk  = 2'b01,
      OwnBus  = 2'b10
   } owner_e;

   typedef struct packed {
      logic inval_live;
      logic inval_reg;
      logic rev_live;
      logic rev_reg;
   } sel_fault_t;

endpackage

// File: rtl/rom_mux_sel_mon.sv
module rom_mux_sel_mon
   import rom_mux_pkg::*;
#(
   parameter sel_t SEL_BUS = SelBus,
   parameter sel_t SEL_CHK = SelChk
) (
   input  logic   clk_i,
   input  logic   rst_ni,
   input  sel_t   sel_i,
   output owner_e owner_o,
   output logic   fault_now_o,
   output logic   fault_q_o
);

   localparam int unsigned CodeDist = $countones(SEL_BUS ^ SEL_CHK);

   if (SEL_BUS == SEL_CHK) begin : g_bad_codes_equal
      $error("select codes must differ");
   end
   if (CodeDist < 2) begin : g_bad_codes_close
      $error("select codes must differ in at least two bits");
   end

   sel_t       sel_q, sel_qq;
   logic       fault_q;
   sel_fault_t flt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sel_q  <= SEL_CHK;
         sel_qq <= SEL_CHK;
      end else begin
         sel_q  <= sel_i;
         sel_qq <= sel_q;
      end
   end

   always_comb begin
      flt.inval_live = (sel_i != SEL_BUS) && (sel_i != SEL_CHK);
      flt.inval_reg  = (sel_q != SEL_BUS) && (sel_q != SEL_CHK);
      flt.rev_live   = (sel_q == SEL_BUS) && (sel_i == SEL_CHK);
      flt.rev_reg    = (sel_qq == SEL_BUS) && (sel_q == SEL_CHK);
   end

   assign fault_now_o = |flt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         fault_q <= 1'b0;
      end else if (fault_now_o) begin
         fault_q <= 1'b1;
      end
   end

   assign fault_q_o = fault_q;

   // Checker access needs both copies at the checker code and a clean history.
   always_comb begin
      if (sel_i == SEL_BUS) begin
         owner_o = OwnBus;
      end else if ((sel_i == SEL_CHK) && (sel_q == SEL_CHK) && !fault_q) begin
         owner_o = OwnChk;
      end else begin
         owner_o = OwnNone;
      end
   end

   a_r3_illegal_code_alerts: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((sel_i != SEL_BUS) && (sel_i != SEL_CHK)) |=> fault_q);

   a_r4_reversion_alerts: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((sel_i == SEL_CHK) && $past(sel_i == SEL_BUS)) |=> fault_q);

   a_r5_alert_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_q |=> fault_q);

endmodule

// File: rtl/rom_mux_addr_path.sv
module rom_mux_addr_path
   import rom_mux_pkg::*;
#(
   parameter int unsigned ADDR_W = 13
) (
   input  owner_e            owner_i,
   input  logic [ADDR_W-1:0] chk_addr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   output logic [ADDR_W-1:0] addr_o
);

   always_comb begin
      unique case (owner_i)
         OwnChk:  addr_o = chk_addr_i;
         OwnBus:  addr_o = bus_addr_i;
         default: addr_o = '0;
      endcase
   end

endmodule

// File: rtl/rom_mux_rsp.sv
module rom_mux_rsp #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              chk_fire_i,
   input  logic              bus_fire_i,
   input  logic              fault_now_i,
   input  logic              fault_q_i,
   input  logic [DATA_W-1:0] rom_rdata_i,
   output logic              chk_rvalid_o,
   output logic [DATA_W-1:0] chk_rdata_o,
   output logic              bus_rvalid_o,
   output logic [DATA_W-1:0] bus_rdata_o
);

   logic chk_pend_q, bus_pend_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chk_pend_q <= 1'b0;
         bus_pend_q <= 1'b0;
      end else begin
         chk_pend_q <= chk_fire_i;
         bus_pend_q <= bus_fire_i;
      end
   end

   assign chk_rvalid_o = chk_pend_q;
   assign chk_rdata_o  = rom_rdata_i;
   assign bus_rvalid_o = bus_pend_q && !fault_q_i && !fault_now_i;
   assign bus_rdata_o  = rom_rdata_i;

   a_r6_chk_rsp_follows_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chk_rvalid_o |-> $past(chk_fire_i));

   a_r7_bus_rsp_follows_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_rvalid_o |-> $past(bus_fire_i));

endmodule

// File: rtl/rom_access_mux.sv
module rom_access_mux
   import rom_mux_pkg::*;
#(
   parameter int unsigned ADDR_W = 13,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [3:0]        own_sel_i,
   input  logic              chk_req_i,
   input  logic [ADDR_W-1:0] chk_addr_i,
   output logic              chk_rvalid_o,
   output logic [DATA_W-1:0] chk_rdata_o,
   input  logic              bus_req_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   output logic              bus_ready_o,
   output logic              bus_rvalid_o,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              rom_req_o,
   output logic [ADDR_W-1:0] rom_addr_o,
   output logic [ADDR_W-1:0] rom_addr_dup_o,
   input  logic [DATA_W-1:0] rom_rdata_i,
   output logic              alert_o
);

   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr_w
      $error("ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("DATA_W must be positive");
   end
   if (NumAddrPaths != 2) begin : g_bad_paths
      $error("exactly two address paths are wired to ports");
   end

   owner_e owner;
   logic   fault_now, fault_q;
   logic   chk_fire, bus_fire;
   logic [ADDR_W-1:0] path_addr [NumAddrPaths];

   rom_mux_sel_mon #(
      .SEL_BUS (SelBus),
      .SEL_CHK (SelChk)
   ) u_sel_mon (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sel_i       (own_sel_i),
      .owner_o     (owner),
      .fault_now_o (fault_now),
      .fault_q_o   (fault_q)
   );

   assign bus_ready_o = (owner == OwnBus);
   assign chk_fire    = chk_req_i && (owner == OwnChk);
   assign bus_fire    = bus_req_i && bus_ready_o;
   assign rom_req_o   = chk_fire || bus_fire;
   assign alert_o     = fault_q;

   for (genvar p = 0; p < NumAddrPaths; p++) begin : g_addr_path
      rom_mux_addr_path #(
         .ADDR_W (ADDR_W)
      ) u_path (
         .owner_i    (owner),
         .chk_addr_i (chk_addr_i),
         .bus_addr_i (bus_addr_i),
         .addr_o     (path_addr[p])
      );
   end

   assign rom_addr_o     = path_addr[0];
   assign rom_addr_dup_o = path_addr[1];

   rom_mux_rsp #(
      .DATA_W (DATA_W)
   ) u_rsp (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .chk_fire_i   (chk_fire),
      .bus_fire_i   (bus_fire),
      .fault_now_i  (fault_now),
      .fault_q_i    (fault_q),
      .rom_rdata_i  (rom_rdata_i),
      .chk_rvalid_o (chk_rvalid_o),
      .chk_rdata_o  (chk_rdata_o),
      .bus_rvalid_o (bus_rvalid_o),
      .bus_rdata_o  (bus_rdata_o)
   );

   a_r8_no_bus_rsp_after_alert: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alert_o |-> !bus_rvalid_o);

   a_r9_paths_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rom_addr_o == rom_addr_dup_o);

   a_r10_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({bus_ready_o, (owner == OwnChk)}));

   a_r1_chk_blocks_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chk_fire |-> !bus_ready_o);

endmodule

// File: tb/rom_access_mux_tb_top.sv
module rom_access_mux_tb_top;

   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned AW = 13;
   localparam int unsigned DW = 32;
   localparam logic [3:0] CODE_CHK = 4'b1001;
   localparam logic [3:0] CODE_BUS = 4'b0110;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    sel = CODE_CHK;
   logic          chk_req = 1'b0, bus_req = 1'b0;
   logic [AW-1:0] chk_addr = '0, bus_addr = '0;
   logic          chk_rvalid, bus_ready, bus_rvalid, rom_req, alert;
   logic [DW-1:0] chk_rdata, bus_rdata, rom_rdata;
   logic [AW-1:0] rom_addr, rom_addr_dup;

   int n_checks = 0;
   int n_errors = 0;
   logic [DW-1:0] q_chk[$];
   logic [DW-1:0] q_bus[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   rom_access_mux #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .own_sel_i(sel),
      .chk_req_i(chk_req), .chk_addr_i(chk_addr),
      .chk_rvalid_o(chk_rvalid), .chk_rdata_o(chk_rdata),
      .bus_req_i(bus_req), .bus_addr_i(bus_addr), .bus_ready_o(bus_ready),
      .bus_rvalid_o(bus_rvalid), .bus_rdata_o(bus_rdata),
      .rom_req_o(rom_req), .rom_addr_o(rom_addr), .rom_addr_dup_o(rom_addr_dup),
      .rom_rdata_i(rom_rdata), .alert_o(alert)
   );

   function automatic logic [DW-1:0] rom_word(logic [AW-1:0] a);
      return ({{(DW-AW){1'b0}}, a} * 32'h9E3779B1) ^ 32'h5A5A0F0F;
   endfunction

   // ROM model: one-cycle read latency
   always_ff @(posedge clk) begin
      if (rom_req) rom_rdata <= rom_word(rom_addr);
   end

   task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   // Monitor: pops expectations as responses appear
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (rst_n) begin
            if (chk_rvalid) begin
               if (q_chk.size() == 0) check_eq("R6 unexpected chk rsp", 1, 0);
               else check_eq("R6 chk rdata", chk_rdata, q_chk.pop_front());
            end
            if (bus_rvalid) begin
               if (q_bus.size() == 0) check_eq("R8 unexpected bus rsp", 1, 0);
               else check_eq("R7 bus rdata", bus_rdata, q_bus.pop_front());
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      n_errors++;
      n_checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (3) step();
      #1;
      check_eq("R5 alert at reset", alert, 0);
      check_eq("R1 bus ready at reset", bus_ready, 0);
      step(); rst_n = 1'b1;

      // R1: checker owns the ROM; bus requests blocked
      for (int i = 0; i < 4; i++) begin
         step();
         chk_req = 1'b1; chk_addr = AW'(i*3 + 1);
         bus_req = 1'b1; bus_addr = AW'(100 + i);
         #1;
         check_eq("R1 rom req from checker", rom_req, 1);
         check_eq("R1 bus ready low", bus_ready, 0);
         check_eq("R9 rom addr", rom_addr, chk_addr);
         check_eq("R9 rom addr dup", rom_addr_dup, chk_addr);
         q_chk.push_back(rom_word(chk_addr));
      end
      step(); chk_req = 1'b0; bus_req = 1'b0;

      // R2: handover to bus; checker ignored
      step(); sel = CODE_BUS; chk_req = 1'b1; chk_addr = 7;
      #1;
      check_eq("R2 bus ready", bus_ready, 1);
      check_eq("R2 checker ignored", rom_req, 0);
      for (int i = 0; i < 5; i++) begin
         step();
         bus_req = 1'b1; bus_addr = AW'(200 + i*17);
         #1;
         check_eq("R2 rom req from bus", rom_req, 1);
         check_eq("R9 rom addr", rom_addr, bus_addr);
         check_eq("R9 rom addr dup", rom_addr_dup, bus_addr);
         q_bus.push_back(rom_word(bus_addr));
      end
      step(); bus_req = 1'b0; chk_req = 1'b0;
      #1;
      check_eq("R5 no alert on clean handover", alert, 0);

      // Coincidence: response due in the cycle the select turns illegal
      step(); bus_req = 1'b1; bus_addr = 50;
      step(); sel = 4'b0000; bus_req = 1'b1; bus_addr = 51;
      #1;
      check_eq("R8 rvalid low in fault cycle", bus_rvalid, 0);
      check_eq("R10 bus ready low on illegal", bus_ready, 0);
      check_eq("R10 rom req low on illegal", rom_req, 0);
      step(); sel = CODE_BUS; bus_req = 1'b1; bus_addr = 52;
      #1;
      check_eq("R3 alert after illegal code", alert, 1);
      check_eq("R2 bus ready back", bus_ready, 1);
      step(); bus_req = 1'b0;
      #1;
      check_eq("R8 rvalid low after alert", bus_rvalid, 0);
      for (int i = 0; i < 3; i++) begin
         step(); #1;
         check_eq("R5 alert sticky", alert, 1);
      end
      check_eq("R7 bus queue drained", q_bus.size(), 0);
      check_eq("R6 chk queue drained", q_chk.size(), 0);

      // R4: reversion to the checker code
      step(); rst_n = 1'b0; sel = CODE_CHK;
      step(); step(); rst_n = 1'b1;
      #1;
      check_eq("R5 alert cleared by reset", alert, 0);
      step(); sel = CODE_BUS;
      step(); bus_req = 1'b1; bus_addr = 333;
      q_bus.push_back(rom_word(333));
      step(); bus_req = 1'b0;
      step(); sel = CODE_CHK; chk_req = 1'b1; chk_addr = 9;
      #1;
      check_eq("R4 no checker regain", rom_req, 0);
      check_eq("R4 alert not yet", alert, 0);
      step(); #1;
      check_eq("R4 alert after reversion", alert, 1);
      check_eq("R4 checker still blocked", rom_req, 0);
      step(); chk_req = 1'b0;

      // R3/R10: illegal code while checker owns
      step(); rst_n = 1'b0;
      step(); step(); rst_n = 1'b1;
      step(); sel = 4'b1111; chk_req = 1'b1; chk_addr = 3;
      #1;
      check_eq("R10 checker not granted on illegal", rom_req, 0);
      step(); #1;
      check_eq("R3 alert after 1111", alert, 1);
      step(); chk_req = 1'b0;
      step(); step();
      check_eq("R7 bus queue empty at end", q_bus.size(), 0);
      check_eq("R6 chk queue empty at end", q_chk.size(), 0);

      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

endmodule